// File: doc/BRIEF.md
# SDRAM Byte-Mask Latency Pipeline

This block models how a synchronous DRAM data port applies its byte masks, seen from the memory side. A mask bit is sampled for each byte lane on every rising clock edge. The same sample acts on both directions, but with different delays:

- **Writes:** the mask acts at once. Write data offered at the same edge is blocked on the masked lanes.
- **Reads:** the mask acts two edges later. It turns off the output enables of the masked lanes, so the read bus floats on those lanes instead of carrying a value.

The read-side delay line shifts on every edge, whether or not a read or a write is in progress. This lets masked and unmasked cycles follow each other back to back, each one taking effect independently. All outputs are registered.

- After an edge, the write enables and masked write data reflect the inputs sampled at that edge.
- After an edge, the read enables and read data reflect the read inputs sampled at that edge, combined with the mask sampled two edges earlier.

Top module: `sdram_dm_pipe`

## Requirements
- R1: Lane i covers data bits [8i+7:8i]. Mask bit i affects only lane i, and a set mask bit (1) means masked.
- R2: After edge k with write valid high, `wr_byte_en_o[i]` equals the inverse of the mask bit i sampled at that same edge k. `wr_data_o` carries the write data sampled at edge k, with lanes that are not enabled forced to zero.
- R3: After an edge where write valid was low, all write enables and all write data bits are zero, whatever the mask.
- R4: After edge k with read valid high, `rd_oe_o[i]` equals the inverse of the mask bit i sampled at edge k-2.
- R5: After an edge where read valid was low, all read output enables are zero, whatever the mask history.
- R6: On each lane, `rd_dq_o` carries the read data sampled at the same edge when that lane's enable is high, and zero when it is low.
- R7: Masks that alternate on consecutive edges each reach the read enables two edges later, with no merging between neighbouring cycles.
- R8: While reset is high (synchronous, active high), all outputs are zero and the read delay line is cleared. The first two reads after reset are therefore unmasked.
- R9: The read delay line samples the mask on every edge, including edges with no read valid, so a mask given in an idle cycle still disables a read two edges later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| byte_mask_i | input | LANES (4) | Per-lane mask, 1 = masked |
| wr_valid_i | input | 1 | Write data present this cycle |
| wr_data_i | input | DATA_W (32) | Incoming write data |
| rd_valid_i | input | 1 | Read data present this cycle |
| rd_data_i | input | DATA_W (32) | Read data from the array |
| wr_byte_en_o | output | LANES (4) | Registered per-lane write enable after masking |
| wr_data_o | output | DATA_W (32) | Registered write data with blocked lanes zeroed |
| rd_oe_o | output | LANES (4) | Registered per-lane output enable of the read bus |
| rd_dq_o | output | DATA_W (32) | Registered read data, zero on disabled lanes |

## Verification
The bench builds the block with its default parameters: 32 data bits, 8-bit lanes and a read mask latency of two.

With only four lanes, every one of the sixteen mask patterns can be applied in both directions. The bench also covers:
- single-lane masks, which expose any crossed lane mapping;
- alternating patterns, which expose a wrong delay depth;
- masks given in idle cycles, which the delay line must still carry;
- the reset window, where a mask held during reset must not leak into the first reads.

// File: rtl/sdram_dm_pkg.sv
package sdram_dm_pkg;
  localparam int unsigned DM_DATA_W_DEF  = 32;
  localparam int unsigned DM_LANE_W_DEF  = 8;
  localparam int unsigned DM_RD_LAT_DEF  = 2;
endpackage

// File: rtl/dm_delay_line.sv
module dm_delay_line #(
  parameter int unsigned LANES = 4,
  parameter int unsigned DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] mask_i,
  output logic [LANES-1:0] tap_o
);

  generate
    if (DEPTH == 0) begin : g_pass
      assign tap_o = mask_i;
    end else begin : g_shift
      logic [LANES-1:0] stage [DEPTH];

      always_ff @(posedge clk) begin
        if (rst) begin
          for (int s = 0; s < DEPTH; s++) stage[s] <= '0;
        end else begin
          stage[0] <= mask_i;
          for (int s = 1; s < DEPTH; s++) stage[s] <= stage[s-1];
        end
      end

      assign tap_o = stage[DEPTH-1];

      AST_DL_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> tap_o == '0); // R8

      if (DEPTH == 2) begin : g_chk2
        AST_DL_TWO_EDGES: assert property (@(posedge clk) disable iff (rst)
          (!$past(rst, 1) && !$past(rst, 2)) |-> tap_o == $past(mask_i, 2)); // R9
      end
    end
  endgenerate

endmodule

// File: rtl/dm_wr_gate.sv
module dm_wr_gate #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [LANES-1:0]        mask_i,
  input  logic                    valid_i,
  input  logic [LANES*LANE_W-1:0] data_i,
  output logic [LANES-1:0]        byte_en_o,
  output logic [LANES*LANE_W-1:0] data_o
);

  logic [LANES-1:0]        en_next;
  logic [LANES*LANE_W-1:0] data_next;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      always_comb begin
        en_next[g] = valid_i & ~mask_i[g];
        data_next[g*LANE_W +: LANE_W] = en_next[g] ? data_i[g*LANE_W +: LANE_W] : '0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_en_o <= '0;
      data_o    <= '0;
    end else begin
      byte_en_o <= en_next;
      data_o    <= data_next;
    end
  end

  AST_WR_SAME_EDGE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(valid_i)) |-> byte_en_o == ~$past(mask_i)); // R2

  AST_WR_IDLE_OFF: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(valid_i)) |-> (byte_en_o == '0 && data_o == '0)); // R3

endmodule

// File: rtl/dm_rd_drive.sv
module dm_rd_drive #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [LANES-1:0]        tap_mask_i,
  input  logic                    valid_i,
  input  logic [LANES*LANE_W-1:0] data_i,
  output logic [LANES-1:0]        oe_o,
  output logic [LANES*LANE_W-1:0] dq_o
);

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      always_ff @(posedge clk) begin
        if (rst) begin
          oe_o[g]                 <= 1'b0;
          dq_o[g*LANE_W +: LANE_W] <= '0;
        end else if (valid_i && !tap_mask_i[g]) begin
          oe_o[g]                 <= 1'b1;
          dq_o[g*LANE_W +: LANE_W] <= data_i[g*LANE_W +: LANE_W];
        end else begin
          oe_o[g]                 <= 1'b0;
          dq_o[g*LANE_W +: LANE_W] <= '0;
        end
      end

      AST_RD_LANE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !oe_o[g] |-> dq_o[g*LANE_W +: LANE_W] == '0); // R6

      AST_RD_LANE_PASS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && oe_o[g]) |-> dq_o[g*LANE_W +: LANE_W] == $past(data_i[g*LANE_W +: LANE_W])); // R6
    end
  endgenerate

  AST_RD_IDLE_OFF: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(valid_i)) |-> oe_o == '0); // R5

endmodule

// File: rtl/sdram_dm_pipe.sv
module sdram_dm_pipe #(
  parameter int unsigned DATA_W      = sdram_dm_pkg::DM_DATA_W_DEF,
  parameter int unsigned LANE_W      = sdram_dm_pkg::DM_LANE_W_DEF,
  parameter int unsigned RD_MASK_LAT = sdram_dm_pkg::DM_RD_LAT_DEF,
  localparam int unsigned LANES      = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LANES-1:0]  byte_mask_i,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [LANES-1:0]  wr_byte_en_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [LANES-1:0]  rd_oe_o,
  output logic [DATA_W-1:0] rd_dq_o
);

  logic [LANES-1:0] rd_tap_mask;

  dm_delay_line #(.LANES(LANES), .DEPTH(RD_MASK_LAT)) u_delay (
    .clk    (clk),
    .rst    (rst),
    .mask_i (byte_mask_i),
    .tap_o  (rd_tap_mask)
  );

  dm_wr_gate #(.LANES(LANES), .LANE_W(LANE_W)) u_wr (
    .clk       (clk),
    .rst       (rst),
    .mask_i    (byte_mask_i),
    .valid_i   (wr_valid_i),
    .data_i    (wr_data_i),
    .byte_en_o (wr_byte_en_o),
    .data_o    (wr_data_o)
  );

  dm_rd_drive #(.LANES(LANES), .LANE_W(LANE_W)) u_rd (
    .clk        (clk),
    .rst        (rst),
    .tap_mask_i (rd_tap_mask),
    .valid_i    (rd_valid_i),
    .data_i     (rd_data_i),
    .oe_o       (rd_oe_o),
    .dq_o       (rd_dq_o)
  );

  AST_RESET_OUTS_ZERO: assert property (@(posedge clk)
    $past(rst) |-> (rd_oe_o == '0 && wr_byte_en_o == '0)); // R8

  generate
    if (RD_MASK_LAT == 2) begin : g_lat2_chk
      AST_RD_MASK_LAT2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst, 1) && !$past(rst, 2) && !$past(rst, 3) && $past(rd_valid_i))
          |-> rd_oe_o == ~$past(byte_mask_i, 3)); // R4
    end
  endgenerate

endmodule

// File: tb/sdram_dm_pipe_bench.sv
module sdram_dm_pipe_bench;
  localparam int unsigned DW = 32;
  localparam int unsigned LN = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [LN-1:0] byte_mask_i = '0;
  logic          wr_valid_i = 1'b0;
  logic [DW-1:0] wr_data_i = '0;
  logic          rd_valid_i = 1'b0;
  logic [DW-1:0] rd_data_i = '0;
  logic [LN-1:0] wr_byte_en_o;
  logic [DW-1:0] wr_data_o;
  logic [LN-1:0] rd_oe_o;
  logic [DW-1:0] rd_dq_o;

  int checks = 0;
  int failures = 0;

  logic [LN-1:0] q_wen[$];
  logic [DW-1:0] q_wdat[$];
  logic [LN-1:0] q_oe[$];
  logic [DW-1:0] q_rdq[$];
  string         q_tag[$];

  logic [LN-1:0] hist1 = '0;
  logic [LN-1:0] hist2 = '0;

  always #2.5 clk = ~clk;

  sdram_dm_pipe u_sdram_dm_pipe (
    .clk          (clk),
    .rst          (rst),
    .byte_mask_i  (byte_mask_i),
    .wr_valid_i   (wr_valid_i),
    .wr_data_i    (wr_data_i),
    .rd_valid_i   (rd_valid_i),
    .rd_data_i    (rd_data_i),
    .wr_byte_en_o (wr_byte_en_o),
    .wr_data_o    (wr_data_o),
    .rd_oe_o      (rd_oe_o),
    .rd_dq_o      (rd_dq_o)
  );

  function automatic logic [DW-1:0] widen(input logic [LN-1:0] en);
    logic [DW-1:0] r;
    for (int i = 0; i < LN; i++) r[i*8 +: 8] = {8{en[i]}};
    return r;
  endfunction

  task automatic step(input logic [LN-1:0] m, input logic wv, input logic [DW-1:0] wd,
                      input logic rv, input logic [DW-1:0] rd, input string tag);
    logic [LN-1:0] e_wen;
    logic [LN-1:0] e_oe;
    byte_mask_i = m;
    wr_valid_i  = wv;
    wr_data_i   = wd;
    rd_valid_i  = rv;
    rd_data_i   = rd;
    e_wen = wv ? ~m : '0;
    e_oe  = rv ? ~hist2 : '0;
    hist2 = hist1;
    hist1 = m;
    @(posedge clk);
    #1;
    q_wen.push_back(e_wen);
    q_wdat.push_back(wd & widen(e_wen));
    q_oe.push_back(e_oe);
    q_rdq.push_back(rd & widen(e_oe));
    q_tag.push_back(tag);
    @(negedge clk);
  endtask

  // monitor: compares after each edge, away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      while (q_tag.size() > 0) begin
        logic [LN-1:0] ew;
        logic [DW-1:0] ed;
        logic [LN-1:0] eo;
        logic [DW-1:0] er;
        string t;
        ew = q_wen.pop_front();
        ed = q_wdat.pop_front();
        eo = q_oe.pop_front();
        er = q_rdq.pop_front();
        t  = q_tag.pop_front();
        checks++;
        if (wr_byte_en_o !== ew || wr_data_o !== ed || rd_oe_o !== eo || rd_dq_o !== er) begin
          failures++;
          $display("FAIL %s wen=%h/%h wdat=%h/%h oe=%h/%h rdq=%h/%h (actual/expected)",
                   t, wr_byte_en_o, ew, wr_data_o, ed, rd_oe_o, eo, rd_dq_o, er);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R8: reset with mask and valids high
    byte_mask_i = '1;
    wr_valid_i  = 1'b1;
    rd_valid_i  = 1'b1;
    wr_data_i   = 32'hDEADBEEF;
    rd_data_i   = 32'hCAFEF00D;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (wr_byte_en_o !== '0 || rd_oe_o !== '0 || wr_data_o !== '0 || rd_dq_o !== '0) begin
      failures++;
      $display("FAIL R8 reset outs wen=%h oe=%h wd=%h rd=%h expected all 0",
               wr_byte_en_o, rd_oe_o, wr_data_o, rd_dq_o);
    end
    rst = 1'b0;
    hist1 = '0;
    hist2 = '0;

    // R8: first two reads after reset are unmasked despite current mask
    step(4'hF, 1'b0, '0, 1'b1, 32'hA5A5A5A5, "R8");
    step(4'hF, 1'b0, '0, 1'b1, 32'h5A5A5A5A, "R8");
    step(4'h0, 1'b0, '0, 1'b1, 32'h12345678, "R4");
    step(4'h0, 1'b0, '0, 1'b1, 32'h9ABCDEF0, "R4");

    // R1: single-lane masks on both directions
    for (int i = 0; i < LN; i++)
      step(4'b0001 << i, 1'b1, 32'h11223344, 1'b1, 32'h55667788, "R1");

    // R2: all write mask patterns, zero latency
    for (int m = 0; m < 16; m++)
      step(m[3:0], 1'b1, 32'hF0E1D2C3 ^ (m * 32'h01010101), 1'b0, '0, "R2");

    // R3: write valid low ignores mask
    step(4'h0, 1'b0, 32'hFFFFFFFF, 1'b0, '0, "R3");
    step(4'h6, 1'b0, 32'h0BADF00D, 1'b0, '0, "R3");

    // R4: all read mask patterns, two-edge latency
    for (int m = 0; m < 16; m++)
      step(m[3:0], 1'b0, '0, 1'b1, 32'h0F1E2D3C + m, "R4");
    step(4'h0, 1'b0, '0, 1'b1, 32'h13579BDF, "R4");
    step(4'h0, 1'b0, '0, 1'b1, 32'h2468ACE0, "R4");

    // R7: alternating masks back to back
    for (int i = 0; i < 8; i++)
      step((i % 2 == 0) ? 4'hF : 4'h0, 1'b0, '0, 1'b1, 32'h3C3C3C3C ^ i, "R7");
    for (int i = 0; i < 6; i++)
      step((i % 2 == 0) ? 4'h9 : 4'h6, 1'b1, 32'h77777777, 1'b1, 32'h88888888, "R7");

    // R9 / R5: mask in idle cycles reaches later read
    step(4'h5, 1'b0, '0, 1'b0, 32'hFFFFFFFF, "R5");
    step(4'h0, 1'b0, '0, 1'b0, 32'hFFFFFFFF, "R5");
    step(4'h0, 1'b0, '0, 1'b1, 32'hFFFFFFFF, "R9");
    step(4'h3, 1'b1, 32'h44444444, 1'b0, '0, "R9");
    step(4'h0, 1'b0, '0, 1'b0, '0, "R5");
    step(4'h0, 1'b0, '0, 1'b1, 32'hFFFFFFFF, "R6");
    step(4'h0, 1'b0, '0, 1'b1, 32'h89ABCDEF, "R6");

    repeat (2) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule